// File: doc/BRIEF.md
# Per-Channel Sample Reducer

This block sits between a converter's result stream and the write side of a result FIFO. Each incoming sample carries a value and a channel tag. Every channel has its own setting for the reduction mode and the group size. The mode is pass-through, mean or median. The group size is 1, 2, 4 or 8 consecutive samples. For each completed group the block forwards exactly one reduced value, tagged with the channel it came from. An averaging-busy flag shows that a partial group is being held.

Both data sides use valid/ready. An input sample is taken on a cycle where `in_valid` and `in_ready` are both high. The output holds `out_valid`, `out_value` and `out_chan` steady until `out_ready` is seen high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer also stalls the sample source. One 32-bit configuration word sets the behaviour of all eight channels.

A group belongs to one channel. A sample for a different channel ends the partial group, discards it, and starts a new group for the new channel. The mode and group size are captured when a group starts and hold until that group ends.

Top module: `sample_reducer`

## Requirements
- R1: A configuration write is visible on `cfg_rdata` on the cycle after `cfg_we`. For channel c, the count code is at bits [2c+1:2c] and the mode code is at bits [2c+17:2c+16].
- R2: A sample is forwarded unchanged, with its channel, on the cycle after it is accepted when its channel's mode code is 0 (none) or 3 (reserved) or its count code is 0.
- R3: Mode code 1 (mean) with count code k (group size 2^k) outputs the sum of the group shifted right by k, truncated, one cycle after the last sample of the group. A group of full-scale samples gives full scale with no overflow.
- R4: Mode code 2 (median) outputs the element at ascending sorted position (N-1)/2, which for even N is the lower of the two middle values. Ties are handled correctly.
- R5: Only the final sample of a group produces an output. Earlier samples of a group produce none.
- R6: A sample whose channel differs from the channel of a partial group discards that partial group. The new sample starts a fresh group, or passes through if its channel is in pass-through.
- R7: `avg_busy` is high from the cycle after the first sample of a multi-sample group until the cycle after its last sample.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, the output values stay stable, and no input is taken. When the output drains, a waiting sample is taken in that same cycle.
- R9: After reset, `out_valid` and `avg_busy` are low, `in_ready` is high and `cfg_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word: count codes low half, mode codes high half |
| cfg_rdata | output | 32 | Current configuration word |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample can be taken |
| in_value | input | RES | Converter result |
| in_chan | input | 3 | Channel tag of the input sample |
| out_valid | output | 1 | Reduced result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_value | output | RES | Reduced value |
| out_chan | output | 3 | Channel tag of the result |
| avg_busy | output | 1 | A partial group is being collected |

## Verification
Every reduced result appears one cycle after the group's final sample is accepted, because a single output register is the only stage. The busy flag and the configuration readback also change one cycle after the edge that takes the sample or the write. The bench drives each stimulus on a falling edge and reads the outputs on the next falling edge, which falls between the capturing edge and the one after it. It leaves one idle cycle between table samples, so each check sees only the result of that one sample. The back-pressure test holds a sample across several stalled cycles. It then checks that the sample is taken on the very edge where the output drains.

// File: rtl/sred_pkg.sv
package sred_pkg;
  typedef enum logic [1:0] {
    RED_PASS   = 2'd0,
    RED_MEAN   = 2'd1,
    RED_MEDIAN = 2'd2,
    RED_RSVD   = 2'd3
  } red_mode_e;

  localparam int unsigned CFG_W  = 32;
  localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/sred_cfg_regs.sv
module sred_cfg_regs #(
  parameter int unsigned NCH = 8,
  parameter int unsigned RW  = sred_pkg::CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RW-1:0]     wdata,
  output logic [RW-1:0]     rdata,
  output logic [2*NCH-1:0]  cnt_codes,
  output logic [2*NCH-1:0]  mode_codes
);
  localparam int unsigned MODE_LSB = RW / 2;

  logic [RW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= wdata;
  end

  assign rdata = word_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cnt_codes[2*c +: 2]  = word_q[2*c +: 2];
    assign mode_codes[2*c +: 2] = word_q[MODE_LSB + 2*c +: 2];
  end

  // R1
  cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == $past(wdata));
endmodule

// File: rtl/sred_median_pick.sv
module sred_median_pick #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned NW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  vals [DEPTH],
  input  logic [NW-1:0] n,
  output logic [W-1:0]  med
);
  logic [NW-1:0]    target;
  logic [DEPTH-1:0] hit;

  // lower middle position of the ascending order
  assign target = (n - NW'(1)) >> 1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rank
    logic [NW-1:0] rank_i;
    always_comb begin
      rank_i = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if ((NW'(j) < n) &&
            ((vals[j] < vals[i]) || ((vals[j] == vals[i]) && (j < i))))
          rank_i = rank_i + NW'(1);
      end
    end
    assign hit[i] = (NW'(i) < n) && (rank_i == target);
  end

  always_comb begin
    med = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit[i]) med = vals[i];
  end

  // R4
  median_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n != '0) |-> $countones(hit) == 1);
endmodule

// File: rtl/sred_out_stage.sv
module sred_out_stage #(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  ld_value,
  input  logic [CW-1:0] ld_chan,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_value,
  output logic [CW-1:0] out_chan,
  output logic          room
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_chan  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_value <= ld_value;
      out_chan  <= ld_chan;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_chan));
endmodule

// File: rtl/sample_reducer.sv
module sample_reducer #(
  parameter int unsigned RES = 12,
  parameter int unsigned NCH = 8,
  localparam int unsigned CW    = $clog2(NCH),
  localparam int unsigned MAX_K = (1 << sred_pkg::CODE_W) - 1,
  localparam int unsigned DEPTH = 1 << MAX_K,
  localparam int unsigned IDXW  = MAX_K,
  localparam int unsigned NW    = MAX_K + 1,
  localparam int unsigned SUMW  = RES + MAX_K
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [sred_pkg::CFG_W-1:0] cfg_wdata,
  output logic [sred_pkg::CFG_W-1:0] cfg_rdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [RES-1:0]             in_value,
  input  logic [CW-1:0]              in_chan,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [RES-1:0]             out_value,
  output logic [CW-1:0]              out_chan,
  output logic                       avg_busy
);
  import sred_pkg::*;

  logic [2*NCH-1:0] cnt_codes, mode_codes;

  sred_cfg_regs #(.NCH(NCH), .RW(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cnt_codes(cnt_codes), .mode_codes(mode_codes)
  );

  // group state
  logic            grp_active;
  logic [CW-1:0]   grp_chan;
  red_mode_e       grp_mode;
  logic [1:0]      grp_k;
  logic [IDXW-1:0] grp_cnt;
  logic [SUMW-1:0] grp_sum;
  logic [RES-1:0]  grp_buf [DEPTH];

  // settings of the arriving sample's channel
  red_mode_e  mode_c;
  logic [1:0] code_c;
  logic       pass_c;
  assign mode_c = red_mode_e'(mode_codes[{in_chan, 1'b0} +: 2]);
  assign code_c = cnt_codes[{in_chan, 1'b0} +: 2];
  assign pass_c = (mode_c == RED_PASS) || (mode_c == RED_RSVD) || (code_c == 2'd0);

  logic            in_fire, cont, last, load;
  red_mode_e       eff_mode;
  logic [1:0]      eff_k;
  logic [IDXW-1:0] slot;
  logic [NW-1:0]   n_eff;
  logic [SUMW-1:0] sum_new;
  logic [RES-1:0]  mean_v, med_v, result;
  logic [RES-1:0]  pick_vals [DEPTH];

  assign in_fire  = in_valid && in_ready;
  assign cont     = grp_active && (in_chan == grp_chan);
  assign eff_mode = cont ? grp_mode : (pass_c ? RED_PASS : mode_c);
  assign eff_k    = cont ? grp_k : (pass_c ? 2'd0 : code_c);
  assign slot     = cont ? grp_cnt : '0;
  assign n_eff    = NW'(1) << eff_k;
  assign last     = ({1'b0, slot} + NW'(1)) == n_eff;
  assign load     = in_fire && last;

  assign sum_new = (cont ? grp_sum : '0) + SUMW'(in_value);
  assign mean_v  = RES'(sum_new >> eff_k);

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      pick_vals[i] = (IDXW'(i) == slot) ? in_value : grp_buf[i];
  end

  sred_median_pick #(.W(RES), .DEPTH(DEPTH)) u_med (
    .clk(clk), .rst_n(rst_n), .vals(pick_vals), .n(n_eff), .med(med_v)
  );

  always_comb begin
    unique case (eff_mode)
      RED_MEAN:   result = mean_v;
      RED_MEDIAN: result = med_v;
      default:    result = in_value;
    endcase
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n)                            grp_buf[s] <= '0;
      else if (in_fire && slot == IDXW'(s))  grp_buf[s] <= in_value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_active <= 1'b0;
      grp_chan   <= '0;
      grp_mode   <= RED_PASS;
      grp_k      <= '0;
      grp_cnt    <= '0;
      grp_sum    <= '0;
    end else if (in_fire) begin
      if (last) begin
        grp_active <= 1'b0;
        grp_cnt    <= '0;
        grp_sum    <= '0;
      end else begin
        grp_active <= 1'b1;
        grp_chan   <= in_chan;
        grp_mode   <= eff_mode;
        grp_k      <= eff_k;
        grp_cnt    <= slot + IDXW'(1);
        grp_sum    <= sum_new;
      end
    end
  end

  assign avg_busy = grp_active;

  sred_out_stage #(.W(RES), .CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_value(result), .ld_chan(in_chan),
    .out_ready(out_ready), .out_valid(out_valid), .out_value(out_value),
    .out_chan(out_chan), .room(in_ready)
  );

  // R5
  no_partial_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !last |=> !out_valid);

  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !avg_busy);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && grp_active && (in_chan != grp_chan) && !last |=> grp_cnt == IDXW'(1));
endmodule

// File: tb/sample_reducer_test.sv
`timescale 1ns/1ps
module sample_reducer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_value = '0;
  logic [2:0]  in_chan = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_value;
  logic [2:0]  out_chan;
  logic        avg_busy;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  sample_reducer #(.RES(12), .NCH(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_chan(in_chan), .out_valid(out_valid),
    .out_ready(out_ready), .out_value(out_value), .out_chan(out_chan),
    .avg_busy(avg_busy)
  );

  // Config: ch0 none/8, ch1 mean/4, ch2 median/4, ch3 median/8,
  // ch4 mean/8, ch5 mean/2, ch6 reserved/4, ch7 median/2
  localparam logic [31:0] CFG_MAIN = 32'hB5A4_67EB;

  // {req[3:0], chan[2:0], value[11:0], exp_valid, exp_value[11:0]}
  localparam int NV = 49;
  localparam logic [31:0] VEC [NV] = '{
    {4'd2,3'd0,12'd100,1'b1,12'd100},   // R2 mode none
    {4'd2,3'd6,12'd777,1'b1,12'd777},   // R2 reserved mode
    {4'd3,3'd1,12'd10,1'b0,12'd0},      // R3 mean of 4
    {4'd3,3'd1,12'd20,1'b0,12'd0},
    {4'd3,3'd1,12'd30,1'b0,12'd0},
    {4'd3,3'd1,12'd41,1'b1,12'd25},
    {4'd4,3'd2,12'd50,1'b0,12'd0},      // R4 median of 4
    {4'd4,3'd2,12'd10,1'b0,12'd0},
    {4'd4,3'd2,12'd40,1'b0,12'd0},
    {4'd4,3'd2,12'd30,1'b1,12'd30},
    {4'd4,3'd3,12'd8,1'b0,12'd0},       // R4 median of 8
    {4'd4,3'd3,12'd1,1'b0,12'd0},
    {4'd4,3'd3,12'd7,1'b0,12'd0},
    {4'd4,3'd3,12'd2,1'b0,12'd0},
    {4'd4,3'd3,12'd6,1'b0,12'd0},
    {4'd4,3'd3,12'd3,1'b0,12'd0},
    {4'd4,3'd3,12'd5,1'b0,12'd0},
    {4'd4,3'd3,12'd4,1'b1,12'd4},
    {4'd3,3'd4,12'd4095,1'b0,12'd0},    // R3 full scale mean of 8
    {4'd3,3'd4,12'd4095,1'b0,12'd0},
    {4'd3,3'd4,12'd4095,1'b0,12'd0},
    {4'd3,3'd4,12'd4095,1'b0,12'd0},
    {4'd3,3'd4,12'd4095,1'b0,12'd0},
    {4'd3,3'd4,12'd4095,1'b0,12'd0},
    {4'd3,3'd4,12'd4095,1'b0,12'd0},
    {4'd3,3'd4,12'd4095,1'b1,12'd4095},
    {4'd3,3'd5,12'd3,1'b0,12'd0},       // R3 truncation
    {4'd3,3'd5,12'd4,1'b1,12'd3},
    {4'd4,3'd7,12'd900,1'b0,12'd0},     // R4 lower middle of 2
    {4'd4,3'd7,12'd5,1'b1,12'd5},
    {4'd4,3'd2,12'd7,1'b0,12'd0},       // R4 ties
    {4'd4,3'd2,12'd7,1'b0,12'd0},
    {4'd4,3'd2,12'd3,1'b0,12'd0},
    {4'd4,3'd2,12'd7,1'b1,12'd7},
    {4'd6,3'd1,12'd1000,1'b0,12'd0},    // R6 cut by pass channel
    {4'd6,3'd1,12'd1000,1'b0,12'd0},
    {4'd6,3'd0,12'd55,1'b1,12'd55},
    {4'd6,3'd1,12'd0,1'b0,12'd0},
    {4'd6,3'd1,12'd0,1'b0,12'd0},
    {4'd6,3'd1,12'd0,1'b0,12'd0},
    {4'd6,3'd1,12'd4,1'b1,12'd1},
    {4'd6,3'd1,12'd500,1'b0,12'd0},     // R6 cut by averaging channel
    {4'd6,3'd5,12'd6,1'b0,12'd0},
    {4'd6,3'd5,12'd8,1'b1,12'd7},
    {4'd6,3'd1,12'd0,1'b0,12'd0},
    {4'd6,3'd1,12'd0,1'b0,12'd0},
    {4'd6,3'd1,12'd0,1'b0,12'd0},
    {4'd6,3'd1,12'd8,1'b1,12'd2},
    {4'd5,3'd0,12'd9,1'b1,12'd9}        // R5 lone pass sample after groups
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [2:0] ch, input logic [11:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_chan = ch;
    in_value = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(avg_busy == 1'b0, "R9 avg_busy", int'(avg_busy), 0);
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    chk(cfg_rdata == 32'd0, "R9 cfg_rdata", int'(cfg_rdata), 0);

    // R1 readback
    write_cfg(CFG_MAIN);
    chk(cfg_rdata == CFG_MAIN, "R1 readback", int'(cfg_rdata), int'(CFG_MAIN));

    // table walk: field positions (R1) drive every row
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      send(v[27:25], v[24:13]);
      chk(out_valid == v[12], $sformatf("R%0d valid row %0d", v[31:28], i),
          int'(out_valid), int'(v[12]));
      if (v[12]) begin
        chk(out_value == v[11:0], $sformatf("R%0d value row %0d", v[31:28], i),
            int'(out_value), int'(v[11:0]));
        chk(out_chan == v[27:25], $sformatf("R%0d chan row %0d", v[31:28], i),
            int'(out_chan), int'(v[27:25]));
      end
    end

    // R7 busy window on a mean-of-4 group
    send(3'd1, 12'd5);
    chk(avg_busy == 1'b1, "R7 busy after first", int'(avg_busy), 1);
    send(3'd1, 12'd5);
    send(3'd1, 12'd5);
    chk(avg_busy == 1'b1, "R7 busy mid group", int'(avg_busy), 1);
    send(3'd1, 12'd5);
    chk(avg_busy == 1'b0, "R7 busy after last", int'(avg_busy), 0);
    chk(out_value == 12'd5, "R7 group result", int'(out_value), 5);

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(3'd0, 12'd11);
    chk(out_valid == 1'b1 && out_value == 12'd11, "R8 first out", int'(out_value), 11);
    chk(in_ready == 1'b0, "R8 in_ready low", int'(in_ready), 0);
    in_valid = 1'b1;
    in_chan = 3'd0;
    in_value = 12'd22;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_value == 12'd11, "R8 held", int'(out_value), 11);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_value == 12'd22, "R8 taken on drain", int'(out_value), 22);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);

    // R2 count code 0 with mean mode on ch0
    write_cfg(32'h0001_0000);
    send(3'd0, 12'd123);
    chk(out_valid == 1'b1 && out_value == 12'd123, "R2 count zero", int'(out_value), 123);
    chk(avg_busy == 1'b0, "R2 no busy", int'(avg_busy), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule